// File: doc/BRIEF.md
# Command-Decoded Serial Slave with Register File and Frame Store

This block is the host-facing serial port of a radio transceiver core. An external controller pulls the active-low select line low, shifts in one command byte on the data input in SPI mode 0, and then either touches one entry of a 64-entry byte register file or streams a whole frame into or out of a 128-byte frame store. The frame store keeps the frame length in entry 0 and the payload in entries 1 to 127. On the core side, the register file has a combinational read port. The frame store has a write port, which the receive path would use to deposit an incoming frame. The core also supplies a link-quality byte, which is appended to frame reads.

All host pins are brought into the system clock domain through synchronizer stages, and SCLK edges are detected there. The host must therefore hold each SCLK level for several system clocks. The internal logic has two parts. A control section tracks the bit count and the access phase. A datapath section holds the shift registers, the storage arrays and the stream pointer. The control section drives the datapath through a small bundle of one-cycle strobes.

Top module: `spiFrameSlave`

## Requirements
- R1: The command byte is decoded as follows: bits[7:6]=11 is a register write and bits[7:6]=10 is a register read, both to the address in bits[5:0]. Bits[7:5]=011 is a frame write and bits[7:5]=001 is a frame read. Any other value (000xxxxx, 010xxxxx) causes the rest of the access to be ignored until select rises: no storage changes and MISO stays low.
- R2: In a register write, the second byte is stored at the addressed entry, and it then appears on the core register read port.
- R3: In a register read, the second byte period returns the addressed entry on MISO, MSB first.
- R4: A register access touches exactly one entry. Any bytes after the data byte have no effect and return zero. After select rises, the next access starts with a fresh command byte.
- R5: In a frame write, the second byte is the frame length. It is clamped to 127 and stored in entry 0. The following bytes go to entries 1, 2, 3 and so on. Payload bytes beyond the 127th are dropped.
- R6: In a frame read, MISO returns, starting with the second byte: the stored length, then that many payload bytes, then the link-quality input, then zero for every further byte.
- R7: Raising select at any byte boundary ends a frame read with no side effect. A later frame read starts again from the length byte.
- R8: Data is sampled on the rising SCLK edge, MSB first. MISO changes only on falling SCLK edges while selected. MISO is zero during the command byte and while deselected.
- R9: A core write-port strobe stores a data byte at the given frame-store index. Index 0 is the length.
- R10: After reset, all register entries and frame-store entries are zero, and MISO is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from host, idle low |
| mosi | input | 1 | Serial data from host |
| selN | input | 1 | Active-low select from host |
| miso | output | 1 | Serial data to host |
| coreRegAddr | input | 6 | Core register read address |
| coreRegData | output | 8 | Register entry at coreRegAddr |
| coreFbWe | input | 1 | Core frame-store write strobe |
| coreFbAddr | input | 7 | Core frame-store write index |
| coreFbData | input | 8 | Core frame-store write data |
| lqi | input | 8 | Link-quality byte for the stored frame |

## Verification
The assertions assume that the host moves SCLK and the select line slowly compared with the system clock. Each SCLK level must last at least a few cycles beyond the synchronizer depth. The assertions also assume that the core write port never targets the frame store while the host is writing a frame. The stimulus keeps to these limits. It holds every SCLK phase for four system clocks, and it changes MOSI only while SCLK is low. It raises and lowers select only with SCLK at rest. It uses the core write port only between accesses. Under these conditions, MISO can change only after a detected falling edge, and the stored length written by the host always stays at or below 127.

// File: rtl/spiFbPkg.sv
package spiFbPkg;

  typedef struct packed {
    logic inCmd;
    logic cmdLatch;
    logic regWr;
    logic regRdLoad;
    logic fbLenWr;
    logic fbPayWr;
    logic fbRdStart;
    logic fbRdNext;
  } fbStrobeT;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_REGWR,
    ST_IGNORE,
    ST_FBLEN,
    ST_FBPAY,
    ST_FBRD
  } ctrlStateT;

endpackage

// File: rtl/spiFbCtrl.sv
module spiFbCtrl
  import spiFbPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       selActive,
  input  logic       sclkRise,
  input  logic [7:0] rxByte,
  output fbStrobeT   strb
);

  logic [2:0] bitCnt;
  ctrlStateT  state, stateNext;
  logic       byteDone;

  assign byteDone = selActive && sclkRise && (bitCnt == 3'd7);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      state  <= ST_CMD;
    end else if (!selActive) begin
      bitCnt <= '0;
      state  <= ST_CMD;
    end else begin
      if (sclkRise) bitCnt <= bitCnt + 3'd1;
      state <= stateNext;
    end
  end

  always_comb begin
    strb       = '0;
    stateNext  = state;
    strb.inCmd = selActive && (state == ST_CMD);
    if (byteDone) begin
      unique case (state)
        ST_CMD: begin
          strb.cmdLatch = 1'b1;
          if (rxByte[7:6] == 2'b11) begin
            stateNext = ST_REGWR;
          end else if (rxByte[7:6] == 2'b10) begin
            strb.regRdLoad = 1'b1;
            stateNext      = ST_IGNORE;
          end else if (rxByte[7:5] == 3'b011) begin
            stateNext = ST_FBLEN;
          end else if (rxByte[7:5] == 3'b001) begin
            strb.fbRdStart = 1'b1;
            stateNext      = ST_FBRD;
          end else begin
            stateNext = ST_IGNORE;
          end
        end
        ST_REGWR: begin
          strb.regWr = 1'b1;
          stateNext  = ST_IGNORE;
        end
        ST_FBLEN: begin
          strb.fbLenWr = 1'b1;
          stateNext    = ST_FBPAY;
        end
        ST_FBPAY: strb.fbPayWr  = 1'b1;
        ST_FBRD:  strb.fbRdNext = 1'b1;
        default:  stateNext = ST_IGNORE;
      endcase
    end
  end

  // R4
  bit_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    !selActive |=> (bitCnt == 3'd0 && state == ST_CMD));

  // R1
  one_action_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.regWr, strb.regRdLoad, strb.fbLenWr, strb.fbPayWr,
              strb.fbRdStart, strb.fbRdNext}));

  // R1
  ignore_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (selActive && state == ST_IGNORE) |=> (state == ST_IGNORE || state == ST_CMD));

endmodule

// File: rtl/spiFbDatapath.sv
module spiFbDatapath
  import spiFbPkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int FB_DEPTH    = 128,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        sclk,
  input  logic                        mosi,
  input  logic                        selN,
  output logic                        miso,
  output logic                        selActive,
  output logic                        sclkRise,
  output logic [7:0]                  rxByte,
  input  fbStrobeT                    strb,
  input  logic [ADDR_W-1:0]           coreRegAddr,
  output logic [7:0]                  coreRegData,
  input  logic                        coreFbWe,
  input  logic [$clog2(FB_DEPTH)-1:0] coreFbAddr,
  input  logic [7:0]                  coreFbData,
  input  logic [7:0]                  lqi
);

  localparam int REG_COUNT = 1 << ADDR_W;
  localparam int FB_AW     = $clog2(FB_DEPTH);
  localparam int PTR_W     = FB_AW + 1;
  localparam int MAX_LEN   = FB_DEPTH - 1;

  logic [SYNC_STAGES-1:0] sclkSync, mosiSync, selSync;
  logic                   sclkPrev, sclkFall, mosiBit;
  logic [7:0]             rxShift, txReg, fbLen, lenClamp, rdNextVal;
  logic                   misoReg;
  logic [ADDR_W-1:0]      addrReg;
  logic [PTR_W-1:0]       ptr, lenP;
  logic [7:0]             regFile [REG_COUNT];
  logic [7:0]             fbMem   [FB_DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSync <= '0;
      mosiSync <= '0;
      selSync  <= '1;
      sclkPrev <= 1'b0;
    end else begin
      sclkSync <= {sclkSync[SYNC_STAGES-2:0], sclk};
      mosiSync <= {mosiSync[SYNC_STAGES-2:0], mosi};
      selSync  <= {selSync[SYNC_STAGES-2:0], selN};
      sclkPrev <= sclkSync[SYNC_STAGES-1];
    end
  end

  assign selActive = !selSync[SYNC_STAGES-1];
  assign mosiBit   = mosiSync[SYNC_STAGES-1];
  assign sclkRise  = selActive && sclkSync[SYNC_STAGES-1] && !sclkPrev;
  assign sclkFall  = selActive && !sclkSync[SYNC_STAGES-1] && sclkPrev;
  assign rxByte    = {rxShift[6:0], mosiBit};
  assign miso      = misoReg;

  assign fbLen     = fbMem[0];
  assign lenP      = PTR_W'(fbLen);
  assign lenClamp  = (rxByte > 8'(MAX_LEN)) ? 8'(MAX_LEN) : rxByte;
  assign coreRegData = regFile[coreRegAddr];

  always_comb begin
    if (ptr <= lenP)                  rdNextVal = fbMem[ptr[FB_AW-1:0]];
    else if (ptr == lenP + PTR_W'(1)) rdNextVal = lqi;
    else                              rdNextVal = 8'h00;
  end

  // serial shift and transmit path
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txReg   <= '0;
      misoReg <= 1'b0;
      addrReg <= '0;
      ptr     <= '0;
    end else if (!selActive) begin
      txReg   <= '0;
      misoReg <= 1'b0;
    end else begin
      if (sclkRise) rxShift <= rxByte;
      if (strb.cmdLatch) addrReg <= rxByte[ADDR_W-1:0];
      if (strb.regRdLoad) begin
        txReg <= regFile[rxByte[ADDR_W-1:0]];
      end else if (strb.fbRdStart) begin
        txReg <= fbLen;
        ptr   <= PTR_W'(1);
      end else if (strb.fbRdNext) begin
        txReg <= rdNextVal;
        if (ptr <= lenP + PTR_W'(1)) ptr <= ptr + PTR_W'(1);
      end else if (sclkFall) begin
        misoReg <= txReg[7];
        txReg   <= {txReg[6:0], 1'b0};
      end
      if (strb.fbLenWr) ptr <= PTR_W'(1);
      else if (strb.fbPayWr && ptr <= PTR_W'(MAX_LEN)) ptr <= ptr + PTR_W'(1);
      else if (strb.fbPayWr) ptr <= PTR_W'(FB_DEPTH);
    end
  end

  // storage arrays
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < REG_COUNT; i++) regFile[i] <= '0;
      for (int i = 0; i < FB_DEPTH; i++)  fbMem[i]   <= '0;
    end else begin
      if (strb.regWr) regFile[addrReg] <= rxByte;
      if (strb.fbLenWr) fbMem[0] <= lenClamp;
      else if (strb.fbPayWr && ptr <= PTR_W'(MAX_LEN)) fbMem[ptr[FB_AW-1:0]] <= rxByte;
      else if (coreFbWe) fbMem[coreFbAddr] <= coreFbData;
    end
  end

  // R8
  miso_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (selActive && !sclkFall) |=> $stable(misoReg));

  // R8
  cmd_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.inCmd |-> !misoReg);

  // R5
  len_clamp_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.fbLenWr |=> (fbMem[0] <= 8'(MAX_LEN)));

  // R5
  ptr_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    ptr <= PTR_W'(FB_DEPTH + 1));

endmodule

// File: rtl/spiFrameSlave.sv
module spiFrameSlave
  import spiFbPkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int FB_DEPTH    = 128,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        sclk,
  input  logic                        mosi,
  input  logic                        selN,
  output logic                        miso,
  input  logic [ADDR_W-1:0]           coreRegAddr,
  output logic [7:0]                  coreRegData,
  input  logic                        coreFbWe,
  input  logic [$clog2(FB_DEPTH)-1:0] coreFbAddr,
  input  logic [7:0]                  coreFbData,
  input  logic [7:0]                  lqi
);

  fbStrobeT   strb;
  logic       selActive, sclkRise;
  logic [7:0] rxByte;

  spiFbCtrl ctrl (
    .clk(clk), .rstN(rstN), .selActive(selActive), .sclkRise(sclkRise),
    .rxByte(rxByte), .strb(strb)
  );

  spiFbDatapath #(
    .ADDR_W(ADDR_W), .FB_DEPTH(FB_DEPTH), .SYNC_STAGES(SYNC_STAGES)
  ) dp (
    .clk(clk), .rstN(rstN), .sclk(sclk), .mosi(mosi), .selN(selN),
    .miso(miso), .selActive(selActive), .sclkRise(sclkRise),
    .rxByte(rxByte), .strb(strb), .coreRegAddr(coreRegAddr),
    .coreRegData(coreRegData), .coreFbWe(coreFbWe), .coreFbAddr(coreFbAddr),
    .coreFbData(coreFbData), .lqi(lqi)
  );

endmodule

// File: tb/spiFrameSlave_test.sv
module spiFrameSlave_test;

  localparam int HALF = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sclk = 1'b0, mosi = 1'b0, selN = 1'b1;
  logic       miso;
  logic [5:0] coreRegAddr = '0;
  logic [7:0] coreRegData;
  logic       coreFbWe = 1'b0;
  logic [6:0] coreFbAddr = '0;
  logic [7:0] coreFbData = '0;
  logic [7:0] lqi = 8'h3C;

  int checks = 0;
  int errors = 0;

  logic [7:0] regModel [64];
  logic [7:0] fbModel  [128];

  always #2 clk = ~clk;

  spiFrameSlave uut (
    .clk(clk), .rstN(rstN), .sclk(sclk), .mosi(mosi), .selN(selN),
    .miso(miso), .coreRegAddr(coreRegAddr), .coreRegData(coreRegData),
    .coreFbWe(coreFbWe), .coreFbAddr(coreFbAddr), .coreFbData(coreFbData),
    .lqi(lqi)
  );

  task automatic checkEq(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic spiByte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = miso;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic selLow();
    selN = 1'b0;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic selHigh();
    repeat (HALF) @(negedge clk);
    selN = 1'b1;
    repeat (3 * HALF) @(negedge clk);
  endtask

  task automatic regWrite(input logic [5:0] a, input logic [7:0] d);
    logic [7:0] rx;
    selLow();
    spiByte({2'b11, a}, rx);
    spiByte(d, rx);
    selHigh();
    regModel[a] = d;
  endtask

  task automatic coreRegCheck(input string req, input logic [5:0] a);
    coreRegAddr = a;
    @(negedge clk);
    checkEq(req, coreRegData, regModel[a]);
  endtask

  task automatic fbWrite(input int len, input int nPay);
    logic [7:0] rx;
    selLow();
    spiByte(8'h60, rx);
    spiByte(8'(len), rx);
    fbModel[0] = (len > 127) ? 8'd127 : 8'(len);
    for (int j = 1; j <= nPay; j++) begin
      spiByte(8'((j * 7 + len) & 255), rx);
      if (j <= 127) fbModel[j] = 8'((j * 7 + len) & 255);
    end
    selHigh();
  endtask

  task automatic fbReadCheck(input string req, input int nBytes);
    logic [7:0] rx, exp;
    int len;
    len = int'(fbModel[0]);
    selLow();
    spiByte(8'h20, rx);
    checkEq("R8", rx, 8'h00);
    for (int k = 0; k < nBytes; k++) begin
      spiByte(8'h00, rx);
      if (k == 0) exp = fbModel[0];
      else if (k <= len) exp = fbModel[k];
      else if (k == len + 1) exp = lqi;
      else exp = 8'h00;
      checkEq(req, rx, exp);
    end
    selHigh();
    checkEq("R8", {7'd0, miso}, 8'h00);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rx;
    for (int i = 0; i < 64; i++) regModel[i] = 8'h00;
    for (int i = 0; i < 128; i++) fbModel[i] = 8'h00;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R10: reset state
    checkEq("R10", {7'd0, miso}, 8'h00);
    coreRegCheck("R10", 6'd0);
    coreRegCheck("R10", 6'd63);
    fbReadCheck("R10", 3);

    // R2: write every register, check through core port
    for (int a = 0; a < 64; a++) regWrite(6'(a), 8'((a * 37 + 5) & 255));
    for (int a = 0; a < 64; a++) coreRegCheck("R2", 6'(a));

    // R3: read every register over the serial port
    for (int a = 0; a < 64; a++) begin
      selLow();
      spiByte({2'b10, 6'(a)}, rx);
      checkEq("R8", rx, 8'h00);
      spiByte(8'h00, rx);
      checkEq("R3", rx, regModel[a]);
      selHigh();
    end

    // R4: trailing bytes after a register access do nothing
    selLow();
    spiByte({2'b11, 6'd5}, rx);
    spiByte(8'h11, rx);
    spiByte(8'hC3, rx);
    spiByte(8'h77, rx);
    selHigh();
    regModel[5] = 8'h11;
    coreRegCheck("R4", 6'd5);
    coreRegCheck("R4", 6'd3);
    selLow();
    spiByte({2'b10, 6'd9}, rx);
    spiByte(8'h00, rx);
    checkEq("R3", rx, regModel[9]);
    spiByte(8'h00, rx);
    checkEq("R4", rx, 8'h00);
    selHigh();
    regWrite(6'd7, 8'hE1);
    coreRegCheck("R4", 6'd7);

    // R1: unassigned command codes are ignored
    foreach (regModel[i]) begin end
    for (int c = 0; c < 6; c++) begin
      logic [7:0] code;
      code = (c == 0) ? 8'h00 : (c == 1) ? 8'h1F : (c == 2) ? 8'h40 :
             (c == 3) ? 8'h45 : (c == 4) ? 8'h5F : 8'h13;
      selLow();
      spiByte(code, rx);
      spiByte(8'hC3, rx);
      checkEq("R1", rx, 8'h00);
      spiByte(8'h77, rx);
      checkEq("R1", rx, 8'h00);
      selHigh();
      coreRegCheck("R1", 6'd3);
      coreRegCheck("R1", code[5:0]);
    end
    fbReadCheck("R1", 2);

    // R5/R6: frame writes and reads of several lengths
    fbWrite(0, 0);
    fbReadCheck("R6", 3);
    lqi = 8'hA5;
    fbWrite(5, 5);
    fbReadCheck("R6", 9);
    fbWrite(1, 1);
    fbReadCheck("R6", 4);
    lqi = 8'h5A;
    fbWrite(127, 127);
    fbReadCheck("R5", 131);
    fbWrite(200, 130);
    fbReadCheck("R5", 130);

    // R7: aborted reads leave no trace
    fbWrite(4, 4);
    fbReadCheck("R7", 1);
    fbReadCheck("R7", 3);
    fbReadCheck("R7", 7);

    // R9: core write port loads the frame store
    for (int i = 0; i < 4; i++) begin
      coreFbAddr = 7'(i);
      coreFbData = (i == 0) ? 8'd3 : 8'(8'h90 + i);
      coreFbWe = 1'b1;
      @(negedge clk);
      coreFbWe = 1'b0;
      fbModel[i] = coreFbData;
    end
    @(negedge clk);
    fbReadCheck("R9", 6);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule